// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Hold and LCD Polarity

This block turns a four-bit binary-coded decimal digit into the seven lines that drive a numeric display. Segment a is the top bar. The segments then run clockwise: b is upper right, c is lower right, d is the bottom, e is lower left and f is upper left. Segment g is the middle bar. A pass control decides whether the block takes a new digit or keeps the one it holds. That lets a multiplexed or slowly changing counter value be frozen on the display.

Two output controls act on the held digit without waiting for a clock edge. A blank control turns every segment off. A polarity control inverts every segment line. For a liquid-crystal panel, the same square wave drives the polarity input and the panel's common plane. A lit segment then always sits in antiphase with the plane, and a dark segment sits in phase with it. Blanking comes before the inversion, so a blanked digit follows the plane exactly.

The hold register is clocked. It has an asynchronous active-low reset, and the reset is released synchronously by the surrounding logic.

Top module: `seg7_lcd_decoder`

## Requirements
- R1: With `seg_o[0]`=a through `seg_o[6]`=g, and with blank and polarity low, the held codes 0 to 9 give 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F.
- R2: Digit 6 includes the top bar a (0x7D). Digit 9 includes the bottom bar d (0x6F). Digit 7 lights only a, b and c (0x07).
- R3: Held codes 10 to 15 light no segment, which is 0x00 with polarity low.
- R4: While `pass_i` is high, the code on `bcd_i` is taken at each rising clock edge. It shows on `seg_o` from that edge on.
- R5: While `pass_i` is low, the held code is kept. A change on `bcd_i` has no effect on `seg_o`.
- R6: With `blank_i` high and `phase_i` low, `seg_o` is 0x00 whatever code is held.
- R7: With `phase_i` high, every segment line is the inverse of its value with `phase_i` low. A blanked digit under high polarity therefore gives 0x7F.
- R8: `blank_i` and `phase_i` change `seg_o` in the same cycle, with no clock edge in between.
- R9: Reset loads code 15 into the hold register, so that during and after reset `seg_o` equals `phase_i` on all seven lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hold register |
| rst_n | input | 1 | Asynchronous active-low reset |
| bcd_i | input | 4 | BCD digit in |
| pass_i | input | 1 | High: take `bcd_i` at each edge. Low: hold the stored code |
| blank_i | input | 1 | High: all segments off, before the inversion |
| phase_i | input | 1 | High: invert all segment lines |
| seg_o | output | 7 | Segment lines, bit 0 = a through bit 6 = g |

## Verification
The bench first checks that the order of blanking and inversion is right. Blank and polarity high together must give all ones. A design that inverted first and then blanked would give all zeros, so its segments would fight the panel's common plane.

The bench also watches the segment shapes that are easy to get wrong. These are the top bar on 6, the bottom bar on 9 and the absence of f on 7. It also feeds the six non-decimal codes, which a careless table would show as letters.

The hold path is checked by changing the input while pass is low and seeing no change. Blank and polarity are changed with no clock edge in between, which catches a design that registered the output controls. A reset in mid-run must return the display to the dark code.

// File: rtl/seg7_pkg.sv
package seg7_pkg;
  localparam int CODE_W = 4;
  localparam int SEG_N  = 7;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_N-1:0]  seg_t;

  // code that lights nothing; used as reset contents of the hold register
  localparam code_t DARK_CODE = code_t'(15);
endpackage

// File: rtl/seg7_code_hold.sv
module seg7_code_hold #(
  parameter int                     W       = 4,
  parameter logic [W-1:0]           RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/seg7_glyph.sv
module seg7_glyph
  import seg7_pkg::*;
(
  input  code_t code,
  output seg_t  raw
);
  // bit order gfedcba
  always_comb begin
    unique case (code)
      code_t'(0): raw = 7'b0111111;
      code_t'(1): raw = 7'b0000110;
      code_t'(2): raw = 7'b1011011;
      code_t'(3): raw = 7'b1001111;
      code_t'(4): raw = 7'b1100110;
      code_t'(5): raw = 7'b1101101;
      code_t'(6): raw = 7'b1111101;
      code_t'(7): raw = 7'b0000111;
      code_t'(8): raw = 7'b1111111;
      code_t'(9): raw = 7'b1101111;
      default:    raw = '0;
    endcase
  end
endmodule

// File: rtl/seg7_polarity.sv
module seg7_polarity #(
  parameter int N = 7
) (
  input  logic [N-1:0] raw,
  input  logic         blank,
  input  logic         invert,
  output logic [N-1:0] drive
);
  // blanking first, then the polarity swap, one gate pair per line
  for (genvar i = 0; i < N; i++) begin : g_line
    logic lit;
    assign lit      = raw[i] & ~blank;
    assign drive[i] = lit ^ invert;
  end
endmodule

// File: rtl/seg7_lcd_decoder.sv
module seg7_lcd_decoder
  import seg7_pkg::*;
#(
  parameter code_t RESET_CODE = DARK_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] bcd_i,
  input  logic              pass_i,
  input  logic              blank_i,
  input  logic              phase_i,
  output logic [SEG_N-1:0]  seg_o
);
  code_t held_code;
  seg_t  raw_seg;

  seg7_code_hold #(.W(CODE_W), .RST_VAL(RESET_CODE)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (pass_i),
    .d       (bcd_i),
    .q       (held_code)
  );

  seg7_glyph u_glyph (
    .code (held_code),
    .raw  (raw_seg)
  );

  seg7_polarity #(.N(SEG_N)) u_pol (
    .raw    (raw_seg),
    .blank  (blank_i),
    .invert (phase_i),
    .drive  (seg_o)
  );
endmodule

// File: rtl/seg7_lcd_decoder_chk.sv
module seg7_lcd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] bcd_i,
  input logic       pass_i,
  input logic       blank_i,
  input logic       phase_i,
  input logic [6:0] seg_o
);
  assert_blank_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_i && !phase_i) |-> (seg_o == 7'h00));

  assert_blank_follows_plane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_i && phase_i) |-> (seg_o == 7'h7F));

  assert_invert_on_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_i |=> ((blank_i == $past(blank_i) && phase_i != $past(phase_i))
                 -> (seg_o == ~$past(seg_o))));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pass_i |=> ((blank_i == $past(blank_i) && phase_i == $past(phase_i))
                 -> $stable(seg_o)));

  assert_non_decimal_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_i && bcd_i > 4'd9) |=> (!blank_i -> (seg_o == {7{phase_i}})));

  assert_load_eight_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_i && bcd_i == 4'd8) |=> ((!blank_i && !phase_i) -> (seg_o == 7'h7F)));
endmodule

bind seg7_lcd_decoder seg7_lcd_decoder_chk chk_i (.*);

// File: tb/seg7_lcd_decoder_tb_top.sv
`timescale 1ns/1ps
module seg7_lcd_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] bcd_i;
  logic       pass_i, blank_i, phase_i;
  logic [6:0] seg_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg7_lcd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bcd_i(bcd_i), .pass_i(pass_i),
    .blank_i(blank_i), .phase_i(phase_i), .seg_o(seg_o)
  );

  // {code, blank, phase, expected}
  localparam int NV = 18;
  localparam logic [12:0] VEC [NV] = '{
    {4'd0, 1'b0, 1'b0, 7'h3F}, {4'd1, 1'b0, 1'b0, 7'h06},
    {4'd2, 1'b0, 1'b0, 7'h5B}, {4'd3, 1'b0, 1'b0, 7'h4F},
    {4'd4, 1'b0, 1'b0, 7'h66}, {4'd5, 1'b0, 1'b0, 7'h6D},
    {4'd6, 1'b0, 1'b0, 7'h7D}, {4'd7, 1'b0, 1'b0, 7'h07},
    {4'd8, 1'b0, 1'b0, 7'h7F}, {4'd9, 1'b0, 1'b0, 7'h6F},
    {4'd10,1'b0, 1'b0, 7'h00}, {4'd12,1'b0, 1'b0, 7'h00},
    {4'd15,1'b0, 1'b0, 7'h00}, {4'd6, 1'b0, 1'b1, 7'h02},
    {4'd7, 1'b0, 1'b1, 7'h78}, {4'd8, 1'b1, 1'b0, 7'h00},
    {4'd9, 1'b1, 1'b1, 7'h7F}, {4'd11,1'b0, 1'b1, 7'h7F}
  };

  task automatic check(input string req, input logic [6:0] got, input logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: seg_o=%h expected %h", req, got, exp);
    end
  endtask

  initial begin
    rst_n = 1'b1; bcd_i = 4'd0; pass_i = 1'b0; blank_i = 1'b0; phase_i = 1'b0;
    #2 rst_n = 1'b0;
    #1 check("R9 reset dark", seg_o, 7'h00);
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset", seg_o, 7'h00);

    // table walk: R1 R2 R3 R4 R6 R7
    pass_i = 1'b1;
    for (int i = 0; i < NV; i++) begin
      bcd_i   = VEC[i][12:9];
      blank_i = VEC[i][8];
      phase_i = VEC[i][7];
      @(negedge clk);
      check($sformatf("R1/R2/R3/R4 vec %0d", i), seg_o, VEC[i][6:0]);
    end

    // R5: hold ignores the data input
    blank_i = 1'b0; phase_i = 1'b0; bcd_i = 4'd3;
    @(negedge clk);
    pass_i = 1'b0; bcd_i = 4'd8;
    @(negedge clk);
    check("R5 hold", seg_o, 7'h4F);
    bcd_i = 4'd1;
    @(negedge clk);
    check("R5 hold again", seg_o, 7'h4F);

    // R8: controls act without a clock edge
    blank_i = 1'b1; #1 check("R8 blank immediate", seg_o, 7'h00);
    phase_i = 1'b1; #1 check("R8/R7 blank+phase", seg_o, 7'h7F);
    blank_i = 1'b0; #1 check("R8/R7 inverted 3", seg_o, 7'h30);
    phase_i = 1'b0; #1 check("R8 back to 3", seg_o, 7'h4F);

    // R9: reset mid-run with polarity high
    @(negedge clk);
    phase_i = 1'b1; rst_n = 1'b0;
    #1 check("R9 mid reset", seg_o, 7'h7F);
    @(negedge clk); rst_n = 1'b1; phase_i = 1'b0;
    #1 check("R9 held dark after reset", seg_o, 7'h00);
    pass_i = 1'b1; bcd_i = 4'd4;
    @(negedge clk);
    check("R4 load after reset", seg_o, 7'h66);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule